// File: doc/BRIEF.md
# Direct-Mapped Instruction Cache with Line Burst Fill

This block sits between an instruction fetch unit and a 32-bit memory bus. It holds 512 bytes of instructions as 32 lines of four 32-bit words, mapped directly by address. Each fetch names one word. On a hit the word comes back one cycle after the request is taken. On a miss the block reads the whole line from the bus as one four-word burst. The burst starts at word 0 of the line and steps through the words in order.

Words coming back from the bus are written straight into the line. The word the fetch unit asked for is also sent to the fetch output in the same cycle it arrives, so the cache array is never read a second time for it. The fetch unit waits while a fill is in progress, and the block takes no new request until the fourth word has landed. A single-cycle invalidate input drops every line at once.

Top module: `fetch_line_cache`

## Requirements
- R1: After reset every line is invalid, so the first fetch to any address is a miss: `fetch_ready_o` is low in the cycle after the request is taken.
- R2: Fetch addresses split as follows: bits [1:0] are ignored, bits [3:2] select the word in the line, bits [8:4] select one of 32 lines, and bits [31:9] form the tag. Two addresses that differ only in bits [1:0] return the same word.
- R3: When a request is taken and hits, `fetch_valid_o` is high exactly one cycle later and carries the stored word. No bus request is made.
- R4: A miss raises `bus_req_o` and holds it for the whole burst. The n-th word read has `bus_addr_o` = line base + 4·n, for n = 0..3.
- R5: The burst moves to the next word only in a cycle where `bus_rdy_i` is high. Any number of wait cycles is allowed before each word.
- R6: The requested word is delivered on `fetch_data_o`, with `fetch_valid_o` high, in the same cycle that `bus_rdy_i` returns it. It equals `bus_data_i` in that cycle.
- R7: `fetch_ready_o` is low from the cycle after a miss is taken until the fourth word has been accepted. It rises in the following cycle.
- R8: After a fill completes, all four words of that line hit.
- R9: A fetch whose tag differs from the stored tag at the same index is a miss. That fill replaces the old line, so the old address then misses.
- R10: A high `inv_i` clears every valid bit in one cycle. A request taken in that same cycle counts as a miss, and its fill leaves the line valid.
- R11: If `inv_i` is high while a fill is in progress, the line being filled stays invalid when the fill ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| inv_i | input | 1 | Invalidate all lines |
| fetch_req_i | input | 1 | Fetch request |
| fetch_addr_i | input | 32 | Fetch byte address |
| fetch_ready_o | output | 1 | Block can take a request this cycle |
| fetch_valid_o | output | 1 | Instruction word valid |
| fetch_data_o | output | 32 | Instruction word |
| bus_req_o | output | 1 | Burst read in progress |
| bus_addr_o | output | 32 | Address of the current burst word |
| bus_rdy_i | input | 1 | Bus returns a word this cycle |
| bus_data_i | input | 32 | Bus read data |

## Verification
The bench sweeps every line, with the missed word at every offset and with zero, one and two wait cycles before each word. It counts the cycles to the critical word and to the return of ready. A design with an off-by-one in the counter, or one that delivers the critical word a cycle late through the array, would return the wrong latency or the wrong word. It would also fail if it stepped the burst without `bus_rdy_i`, or started the burst at the missed word instead of word 0; the bench model checks each burst address. It then hits all 128 words with varied low address bits, forces a tag conflict and an eviction, and pulses invalidate alone, together with a request, and in the middle of a fill. A design that marks a line valid after an invalidate during its fill would show a hit where the bench expects a miss.

// File: rtl/icache_pkg.sv
package icache_pkg;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;
  localparam int LINES  = 32;
  localparam int WPL    = 4;
  localparam int BYTE_W = 2;
  localparam int OFF_W  = $clog2(WPL);
  localparam int IDX_W  = $clog2(LINES);
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W - BYTE_W;
  localparam int LO_W   = BYTE_W + OFF_W;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [DATA_W-1:0] word_t;
  typedef logic [OFF_W-1:0]  off_t;
  typedef logic [IDX_W-1:0]  idx_t;
  typedef logic [TAG_W-1:0]  tag_t;

  function automatic off_t word_of(addr_t a);
    return a[BYTE_W +: OFF_W];
  endfunction

  function automatic idx_t index_of(addr_t a);
    return a[LO_W +: IDX_W];
  endfunction

  function automatic tag_t tag_of(addr_t a);
    return a[ADDR_W-1 -: TAG_W];
  endfunction

  function automatic addr_t line_base(addr_t a);
    return {a[ADDR_W-1:LO_W], {LO_W{1'b0}}};
  endfunction

  function automatic addr_t beat_addr(addr_t base, off_t w);
    return base | (addr_t'(w) << BYTE_W);
  endfunction
endpackage

// File: rtl/icache_tags.sv
module icache_tags
  import icache_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic inv,
  input  idx_t look_idx,
  input  tag_t look_tag,
  output logic look_hit,
  input  logic fill_start,
  input  logic fill_done,
  input  idx_t fill_idx,
  input  tag_t fill_tag
);
  logic [LINES-1:0] valid_q;
  tag_t             tag_q [LINES];
  logic             drop_q;
  logic             fill_commit;

  assign look_hit    = valid_q[look_idx] && (tag_q[look_idx] == look_tag) && !inv;
  assign fill_commit = fill_done && !inv && !drop_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      drop_q  <= 1'b0;
    end else begin
      if (fill_start)   drop_q <= 1'b0;
      else if (inv)     drop_q <= 1'b1;
      if (inv)          valid_q <= '0;
      else if (fill_commit) valid_q[fill_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_commit) tag_q[fill_idx] <= fill_tag;
  end

  p_inv_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    inv |=> (valid_q == '0));
  p_fill_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fill_commit |=> valid_q[$past(fill_idx)]);
  p_drop_keeps_invalid_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_done && drop_q) |=> !valid_q[$past(fill_idx)]);
endmodule

// File: rtl/icache_fill.sv
module icache_fill
  import icache_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  start,
  input  addr_t start_addr,
  input  logic  bus_rdy,
  output logic  busy,
  output logic  bus_req,
  output addr_t bus_addr,
  output logic  beat,
  output off_t  beat_off,
  output logic  done
);
  localparam off_t LAST = off_t'(WPL - 1);

  logic  busy_q;
  off_t  cnt_q;
  addr_t base_q;

  assign busy     = busy_q;
  assign bus_req  = busy_q;
  assign bus_addr = beat_addr(base_q, cnt_q);
  assign beat     = busy_q && bus_rdy;
  assign beat_off = cnt_q;
  assign done     = beat && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      base_q <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
      base_q <= line_base(start_addr);
    end else if (beat) begin
      cnt_q <= cnt_q + off_t'(1);
      if (done) busy_q <= 1'b0;
    end
  end

  p_first_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> (word_of(bus_addr) == '0));
  p_hold_on_wait_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_rdy) |=> (bus_req && $stable(bus_addr)));
  p_no_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> !start);
endmodule

// File: rtl/icache_data.sv
module icache_data
  import icache_pkg::*;
(
  input  logic  clk,
  input  logic  we,
  input  idx_t  widx,
  input  off_t  woff,
  input  word_t wdata,
  input  logic  re,
  input  idx_t  ridx,
  input  off_t  roff,
  output word_t rdata
);
  word_t mem [LINES*WPL];
  word_t rdata_q;

  assign rdata = rdata_q;

  always_ff @(posedge clk) begin
    if (we) mem[{widx, woff}] <= wdata;
    if (re) rdata_q <= mem[{ridx, roff}];
  end
endmodule

// File: rtl/fetch_line_cache.sv
module fetch_line_cache
  import icache_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        inv_i,
  input  logic        fetch_req_i,
  input  logic [31:0] fetch_addr_i,
  output logic        fetch_ready_o,
  output logic        fetch_valid_o,
  output logic [31:0] fetch_data_o,
  output logic        bus_req_o,
  output logic [31:0] bus_addr_o,
  input  logic        bus_rdy_i,
  input  logic [31:0] bus_data_i
);
  logic  busy, beat, done, look_hit;
  logic  accept, hit_acc, miss_acc, crit;
  logic  hit_q;
  off_t  beat_off;
  addr_t miss_addr_q;
  word_t rd_word;

  assign accept   = fetch_req_i && !busy;
  assign hit_acc  = accept && look_hit;
  assign miss_acc = accept && !look_hit;
  assign crit     = beat && (beat_off == word_of(miss_addr_q));

  icache_tags u_tags (
    .clk(clk), .rst_n(rst_n), .inv(inv_i),
    .look_idx(index_of(fetch_addr_i)), .look_tag(tag_of(fetch_addr_i)),
    .look_hit(look_hit),
    .fill_start(miss_acc), .fill_done(done),
    .fill_idx(index_of(miss_addr_q)), .fill_tag(tag_of(miss_addr_q))
  );

  icache_fill u_fill (
    .clk(clk), .rst_n(rst_n), .start(miss_acc), .start_addr(fetch_addr_i),
    .bus_rdy(bus_rdy_i), .busy(busy), .bus_req(bus_req_o), .bus_addr(bus_addr_o),
    .beat(beat), .beat_off(beat_off), .done(done)
  );

  icache_data u_data (
    .clk(clk), .we(beat), .widx(index_of(miss_addr_q)), .woff(beat_off),
    .wdata(bus_data_i), .re(hit_acc), .ridx(index_of(fetch_addr_i)),
    .roff(word_of(fetch_addr_i)), .rdata(rd_word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hit_q       <= 1'b0;
      miss_addr_q <= '0;
    end else begin
      hit_q <= hit_acc;
      if (miss_acc) miss_addr_q <= fetch_addr_i;
    end
  end

  assign fetch_ready_o = !busy;
  assign fetch_valid_o = hit_q || crit;
  assign fetch_data_o  = crit ? bus_data_i : rd_word;

  p_hit_no_bus_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hit_acc |=> (fetch_valid_o && !bus_req_o));
  p_single_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(hit_q && crit));
  p_miss_stalls_r7: assert property (@(posedge clk) disable iff (!rst_n)
    miss_acc |=> (bus_req_o && !fetch_ready_o));
  p_ready_after_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> fetch_ready_o);
endmodule

// File: tb/fetch_line_cache_test.sv
`timescale 1ns/100ps
module fetch_line_cache_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        inv_i = 1'b0;
  logic        fetch_req_i = 1'b0;
  logic [31:0] fetch_addr_i = '0;
  logic        fetch_ready_o, fetch_valid_o, bus_req_o;
  logic [31:0] fetch_data_o, bus_addr_o;
  logic        bus_rdy_i = 1'b0;
  logic [31:0] bus_data_i = '0;

  int checks = 0;
  int fails  = 0;
  int wait_n = 0;
  logic [31:0] exp_base = '0;
  bit finished = 0;

  always #2 clk = ~clk;

  fetch_line_cache uut (.*);

  function automatic logic [31:0] memfn(logic [31:0] a);
    logic [31:0] w = {a[31:2], 2'b00};
    return (w * 32'h9E37_79B1) ^ 32'h1234_5678;
  endfunction

  function automatic logic [31:0] mk(int tag, int line, int word, int lo);
    return (32'(tag) << 9) | (32'(line) << 4) | (32'(word) << 2) | 32'(lo);
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // bus responder: wait_n idle cycles before each word, checks burst order (R4)
  initial begin
    int wc = 0;
    int bw = 0;
    forever begin
      @(negedge clk);
      if (bus_req_o) begin
        if (wc == wait_n) begin
          check(bus_addr_o == exp_base + 32'(bw * 4), "R4 burst addr", bus_addr_o,
                exp_base + 32'(bw * 4));
          bus_rdy_i  = 1'b1;
          bus_data_i = memfn(bus_addr_o);
          wc = 0;
          bw++;
        end else begin
          bus_rdy_i = 1'b0;
          wc++;
        end
      end else begin
        bus_rdy_i = 1'b0;
        wc = 0;
        bw = 0;
      end
    end
  end

  // mode 0: plain, 1: invalidate with request, 2: invalidate during fill
  task automatic fetch(logic [31:0] a, bit exp_miss, int w, int mode);
    int n = 0;
    int k = int'(a[3:2]);
    bit miss;
    wait_n = w;
    exp_base = {a[31:4], 4'b0};
    @(negedge clk);
    while (!fetch_ready_o) @(negedge clk);
    fetch_req_i = 1'b1;
    fetch_addr_i = a;
    inv_i = (mode == 1);
    @(negedge clk);
    fetch_req_i = 1'b0;
    inv_i = 1'b0;
    #1;
    miss = !fetch_ready_o;
    check(miss == exp_miss, exp_miss ? "R1/R9/R10/R11 expected miss" : "R3/R8 expected hit",
          32'(miss), 32'(exp_miss));
    if (mode == 2) inv_i = 1'b1;
    while (!fetch_valid_o && n < 200) begin
      @(negedge clk);
      inv_i = 1'b0;
      #1;
      n++;
    end
    inv_i = 1'b0;
    check(fetch_data_o == memfn(a), "R6/R3/R2 data", fetch_data_o, memfn(a));
    if (exp_miss) begin
      check(n == k * (w + 1) + w, "R5/R6 critical latency", 32'(n), 32'(k * (w + 1) + w));
      check(bus_rdy_i == 1'b1, "R6 same cycle as bus word", 32'(bus_rdy_i), 32'd1);
      while (!fetch_ready_o && n < 200) begin
        @(negedge clk);
        #1;
        n++;
      end
      check(n == 4 * (w + 1), "R7 ready return", 32'(n), 32'(4 * (w + 1)));
    end else begin
      check(n == 0, "R3 hit latency", 32'(n), 32'd0);
      check(bus_req_o == 1'b0, "R3 no bus on hit", 32'(bus_req_o), 32'd0);
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check(fetch_valid_o == 1'b0, "R1 reset valid", 32'(fetch_valid_o), 32'd0);
    check(bus_req_o == 1'b0, "R1 reset bus", 32'(bus_req_o), 32'd0);
    check(fetch_ready_o == 1'b1, "R1 reset ready", 32'(fetch_ready_o), 32'd1);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 R4 R5 R6 R7: fill every line, varied offset and wait states
    for (int ln = 0; ln < 32; ln++)
      fetch(mk(16'h0A5, ln, ln % 4, 0), 1'b1, ln % 3, 0);
    // R8 R2: every word hits, low bits varied
    for (int ln = 0; ln < 32; ln++)
      for (int wd = 0; wd < 4; wd++)
        fetch(mk(16'h0A5, ln, wd, (ln + wd) % 4), 1'b0, 0, 0);
    // R9: conflict then eviction
    fetch(mk(16'h133, 5, 2, 0), 1'b1, 1, 0);
    fetch(mk(16'h133, 5, 0, 3), 1'b0, 0, 0);
    fetch(mk(16'h0A5, 5, 1, 0), 1'b1, 0, 0);
    // R10: invalidate alone
    @(negedge clk);
    inv_i = 1'b1;
    @(negedge clk);
    inv_i = 1'b0;
    fetch(mk(16'h0A5, 7, 3, 0), 1'b1, 2, 0);
    fetch(mk(16'h0A5, 7, 0, 0), 1'b0, 0, 0);
    // R10: invalidate in the request cycle, fill still valid afterwards
    fetch(mk(16'h0A5, 7, 1, 0), 1'b1, 0, 1);
    fetch(mk(16'h0A5, 7, 2, 0), 1'b0, 0, 0);
    // R11: invalidate during fill leaves the line invalid
    fetch(mk(16'h0A5, 9, 2, 0), 1'b1, 1, 2);
    fetch(mk(16'h0A5, 9, 2, 0), 1'b1, 0, 0);
    fetch(mk(16'h0A5, 9, 3, 1), 1'b0, 0, 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule